// File: doc/BRIEF.md
# UART Receive Buffer and Status Flags

This block holds the receive-side data and the error and transmit status of a serial port. It sits between the serial shift engines and the CPU register port. The receive engine presents a one-cycle frame-done strobe with the received byte and two check results: parity mismatch and missing stop bit. The block captures the byte in a one-entry buffer and records parity, framing and overrun errors in an 8-bit read-only status register. A transmit-busy bit in the same register is set by a write to the transmit register and cleared by the end-of-transmission strobe.

Error flags are sticky. A frame without an error leaves an earlier flag set, and repeated errors of one kind still show as a single set bit. Software reads the status register first and then reads the buffer. The buffer read, signalled by a one-cycle strobe, clears all three error flags and marks the buffer empty. When a frame completes while the buffer still holds unread data, the new byte replaces the old one and the overrun flag is set. The block also raises a one-cycle receive-done interrupt for every completed frame, and a separate error interrupt when that frame raises any error.

Top module: `rx_status_block`

## Requirements
- R1: While `rst_n` is low at a clock edge, `status`, `rx_data`, `irq_rx_done` and `irq_rx_err` become 0 and the buffer becomes empty.
- R2: `status` bit 7 is the transmit-busy flag, bit 2 the parity error, bit 1 the framing error and bit 0 the overrun error. Bits 6 to 3 always read 0.
- R3: `tx_load` sets bit 7 of `status` from the next cycle on. `tx_end` clears it from the next cycle on. When both strobes arrive in the same cycle, the bit is set.
- R4: `frame_done` loads `frame_byte` into the buffer, and `rx_data` shows the new byte from the next cycle on. With no frame, `rx_data` holds its value.
- R5: A frame with `frame_par_bad` high sets status bit 2. A later frame without a parity error leaves the bit set. Only a buffer read clears it.
- R6: A frame with `frame_stop_bad` high sets status bit 1. A later frame without a stop error leaves the bit set. Only a buffer read clears it.
- R7: When a frame completes while the buffer is full and `buf_rd` is low, status bit 0 is set and the old byte in `rx_data` is replaced by the new one.
- R8: `buf_rd` with no frame in the same cycle clears status bits 2 to 0 and empties the buffer from the next cycle on. Bit 7 and `rx_data` are not changed.
- R9: When `buf_rd` and `frame_done` arrive in the same cycle, the read is handled first. Bits 2 to 0 then show only the new frame's parity and stop errors, bit 0 is 0, and `rx_data` holds the new byte.
- R10: `irq_rx_done` is high for exactly the one cycle after each cycle in which `frame_done` is high.
- R11: `irq_rx_err` is high in the cycle after a frame that has a parity error, a stop error or an overrun, and it is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_done | input | 1 | One-cycle strobe: a received frame is complete |
| frame_byte | input | 8 | Received data byte, valid with `frame_done` |
| frame_par_bad | input | 1 | Parity mismatch on this frame, valid with `frame_done` |
| frame_stop_bad | input | 1 | No valid stop bit on this frame, valid with `frame_done` |
| tx_load | input | 1 | One-cycle strobe: the CPU wrote the transmit register |
| tx_end | input | 1 | One-cycle strobe: transmission finished |
| buf_rd | input | 1 | One-cycle strobe: the CPU reads the receive buffer |
| status | output | 8 | Status register: transmit busy, parity, framing and overrun flags |
| rx_data | output | 8 | Receive buffer contents |
| irq_rx_done | output | 1 | Receive-complete interrupt pulse |
| irq_rx_err | output | 1 | Receive-error interrupt pulse |

## Verification
The assertions treat every input strobe as a level sampled once per clock. They assume that `frame_par_bad`, `frame_stop_bad` and `frame_byte` carry meaning only while `frame_done` is high, and that reset is released synchronously. The stimulus changes every input only at the falling clock edge, so each rising edge sees one stable set of strobes. The random mix includes cycles where a frame meets a buffer read, where a frame arrives while the buffer is full, and where both transmit strobes arrive together. Because error bits on frames without `frame_done` are random, the bench also shows that those bits are ignored.

// File: rtl/rsb_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the receive buffer / status block.
// Assumes the error vector is ordered overrun, framing, parity from bit 0,
// which is also the order of those flags in the status register.
package rsb_pkg;
    localparam int ERR_N   = 3;
    localparam int ERR_OVR = 0;
    localparam int ERR_FRM = 1;
    localparam int ERR_PAR = 2;
    typedef logic [ERR_N-1:0] err_vec_t;
endpackage

// File: rtl/rsb_rx_store.sv
`timescale 1ns/1ps
// One-entry receive buffer with an unread-data marker.
// Assumes frame_done and buf_rd are single-cycle strobes. A read in the
// same cycle as a frame consumes the old byte first, so no overrun occurs then.
module rsb_rx_store #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done,
    input  logic [DATA_W-1:0] frame_byte,
    input  logic              buf_rd,
    output logic [DATA_W-1:0] data_q,
    output logic              overrun_evt
);
    logic full_q;

    // Overrun: a new frame lands on unread data that is not being read now.
    assign overrun_evt = frame_done && full_q && !buf_rd;

    // Buffer contents: replaced on every completed frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (frame_done)
            data_q <= frame_byte;
    end

    // Unread marker: a frame sets it, a read alone clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            full_q <= 1'b0;
        else if (frame_done)
            full_q <= 1'b1;
        else if (buf_rd)
            full_q <= 1'b0;
    end
endmodule

// File: rtl/rsb_err_flags.sv
`timescale 1ns/1ps
// Bank of sticky error flags. Each flag is cleared by the clear strobe and
// set by its event. When both happen in one cycle the clear comes first, so
// the flag then reflects only the new event.
module rsb_err_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [N-1:0] set_vec,
    output logic [N-1:0] flag_q
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        // Flag g: clear-then-set update.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q[g] <= 1'b0;
            else
                flag_q[g] <= (flag_q[g] && !clr) || set_vec[g];
        end
    end
endmodule

// File: rtl/rsb_tx_flag.sv
`timescale 1ns/1ps
// Transmit-busy flag. It is set by a transmit-register write and cleared by
// the end-of-transmission strobe. A write wins when both arrive together,
// because it starts a new transmission.
module rsb_tx_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_load,
    input  logic tx_end,
    output logic busy_q
);
    // Set/clear register with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_q <= 1'b0;
        else if (tx_load)
            busy_q <= 1'b1;
        else if (tx_end)
            busy_q <= 1'b0;
    end
endmodule

// File: rtl/rx_status_block.sv
`timescale 1ns/1ps
// Receive buffer and status register of a serial port.
// Assumes all inputs are synchronous to clk and strobes last one cycle.
// The error inputs are meaningful only together with frame_done.
// The status register is read-only. The error bits are cleared by a buffer read.
module rx_status_block #(
    parameter int DATA_W = 8,
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done,
    input  logic [DATA_W-1:0] frame_byte,
    input  logic              frame_par_bad,
    input  logic              frame_stop_bad,
    input  logic              tx_load,
    input  logic              tx_end,
    input  logic              buf_rd,
    output logic [STAT_W-1:0] status,
    output logic [DATA_W-1:0] rx_data,
    output logic              irq_rx_done,
    output logic              irq_rx_err
);
    import rsb_pkg::*;

    localparam int TX_BIT = STAT_W - 1;

    logic     overrun_evt;
    logic     tx_busy;
    err_vec_t err_set;
    err_vec_t err_q;

    rsb_rx_store #(.DATA_W(DATA_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_done  (frame_done),
        .frame_byte  (frame_byte),
        .buf_rd      (buf_rd),
        .data_q      (rx_data),
        .overrun_evt (overrun_evt)
    );

    // Error events of this cycle, in status-bit order.
    always_comb begin
        err_set          = '0;
        err_set[ERR_PAR] = frame_done && frame_par_bad;
        err_set[ERR_FRM] = frame_done && frame_stop_bad;
        err_set[ERR_OVR] = overrun_evt;
    end

    rsb_err_flags #(.N(ERR_N)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (buf_rd),
        .set_vec (err_set),
        .flag_q  (err_q)
    );

    rsb_tx_flag u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_load (tx_load),
        .tx_end  (tx_end),
        .busy_q  (tx_busy)
    );

    // Status assembly: busy at the top bit, errors at the bottom, the rest zero.
    always_comb begin
        status               = '0;
        status[ERR_N-1:0]    = err_q;
        status[TX_BIT]       = tx_busy;
    end

    // Interrupt pulses, one cycle after the frame, aligned with the flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_rx_done <= 1'b0;
            irq_rx_err  <= 1'b0;
        end else begin
            irq_rx_done <= frame_done;
            irq_rx_err  <= |err_set;
        end
    end
endmodule

// File: rtl/rx_status_block_chk.sv
`timescale 1ns/1ps
// Protocol checker for rx_status_block. It observes the ports only.
module rx_status_block_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_done,
    input logic [7:0] frame_byte,
    input logic       frame_par_bad,
    input logic       frame_stop_bad,
    input logic       tx_load,
    input logic       tx_end,
    input logic       buf_rd,
    input logic [7:0] status,
    input logic [7:0] rx_data,
    input logic       irq_rx_done,
    input logic       irq_rx_err
);
    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        status[6:3] == 4'b0000);
    assert_tx_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> status[7]);
    assert_tx_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_end && !tx_load) |=> !status[7]);
    assert_data_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (rx_data == $past(frame_byte)));
    assert_par_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && frame_par_bad) |=> status[2]);
    assert_frm_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && frame_stop_bad) |=> status[1]);
    assert_rd_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd && !frame_done) |=> (status[2:0] == 3'b000));
    assert_rd_keep_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd && !tx_load && !tx_end) |=> $stable(status[7]));
    assert_collide_no_ovr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd && frame_done) |=> !status[0]);
    assert_irq_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> irq_rx_done);
    assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> !irq_rx_done);
    assert_err_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx_err |-> irq_rx_done);
endmodule

bind rx_status_block rx_status_block_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .frame_done     (frame_done),
    .frame_byte     (frame_byte),
    .frame_par_bad  (frame_par_bad),
    .frame_stop_bad (frame_stop_bad),
    .tx_load        (tx_load),
    .tx_end         (tx_end),
    .buf_rd         (buf_rd),
    .status         (status),
    .rx_data        (rx_data),
    .irq_rx_done    (irq_rx_done),
    .irq_rx_err     (irq_rx_err)
);

// File: tb/rx_status_block_tb.sv
`timescale 1ns/1ps
module rx_status_block_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_done = 1'b0;
    logic [7:0] frame_byte = 8'h00;
    logic       frame_par_bad = 1'b0;
    logic       frame_stop_bad = 1'b0;
    logic       tx_load = 1'b0;
    logic       tx_end = 1'b0;
    logic       buf_rd = 1'b0;
    logic [7:0] status;
    logic [7:0] rx_data;
    logic       irq_rx_done;
    logic       irq_rx_err;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // Reference state
    logic       m_full, m_pe, m_fe, m_ove, m_tx, m_irqd, m_irqe;
    logic [7:0] m_data;

    always #10 clk = ~clk;

    rx_status_block u_dut (
        .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_byte(frame_byte),
        .frame_par_bad(frame_par_bad), .frame_stop_bad(frame_stop_bad),
        .tx_load(tx_load), .tx_end(tx_end), .buf_rd(buf_rd),
        .status(status), .rx_data(rx_data),
        .irq_rx_done(irq_rx_done), .irq_rx_err(irq_rx_err)
    );

    function automatic logic [7:0] exp_status();
        return {m_tx, 4'b0000, m_pe, m_fe, m_ove};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_full = 0; m_pe = 0; m_fe = 0; m_ove = 0; m_tx = 0;
        m_irqd = 0; m_irqe = 0; m_data = 8'h00;
    endtask

    // Advance the reference by one clock with the given strobes.
    task automatic model_step(input logic fd, input logic [7:0] b, input logic pb,
                              input logic sb, input logic ld, input logic te, input logic rd);
        logic ovr;
        ovr    = fd && m_full && !rd;
        m_pe   = (m_pe && !rd) || (fd && pb);
        m_fe   = (m_fe && !rd) || (fd && sb);
        m_ove  = (m_ove && !rd) || ovr;
        m_full = fd ? 1'b1 : (rd ? 1'b0 : m_full);
        if (fd) m_data = b;
        m_tx   = ld ? 1'b1 : (te ? 1'b0 : m_tx);
        m_irqd = fd;
        m_irqe = fd && (pb || sb || ovr);
    endtask

    task automatic compare_all();
        chk("R2 reserved", {4'h0, status[6:3]}, 8'h00);
        chk("R3 tx busy", {7'h0, status[7]}, {7'h0, m_tx});
        chk("R4/R7 rx_data", rx_data, m_data);
        chk("R5 parity", {7'h0, status[2]}, {7'h0, m_pe});
        chk("R6 framing", {7'h0, status[1]}, {7'h0, m_fe});
        chk("R7 overrun", {7'h0, status[0]}, {7'h0, m_ove});
        chk("R10 irq_rx_done", {7'h0, irq_rx_done}, {7'h0, m_irqd});
        chk("R11 irq_rx_err", {7'h0, irq_rx_err}, {7'h0, m_irqe});
    endtask

    // One clock: drive on the falling edge, sample shortly after the rising edge.
    task automatic step(input logic fd, input logic [7:0] b, input logic pb,
                        input logic sb, input logic ld, input logic te, input logic rd);
        @(negedge clk);
        frame_done = fd; frame_byte = b; frame_par_bad = pb; frame_stop_bad = sb;
        tx_load = ld; tx_end = te; buf_rd = rd;
        model_step(fd, b, pb, sb, ld, te, rd);
        @(posedge clk);
        #2;
        compare_all();
    endtask

    task automatic idle();
        step(0, 8'h00, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        model_reset();
        // R1: outputs after reset
        frame_done = 1; frame_byte = 8'hA5; frame_par_bad = 1; tx_load = 1;
        repeat (3) @(posedge clk);
        #2;
        chk("R1 status", status, 8'h00);
        chk("R1 rx_data", rx_data, 8'h00);
        chk("R1 irqs", {6'h0, irq_rx_done, irq_rx_err}, 8'h00);
        @(negedge clk);
        frame_done = 0; frame_par_bad = 0; tx_load = 0;
        rst_n = 1;
        idle();

        // R5/R6: a clean frame does not clear earlier errors
        step(1, 8'h11, 1, 0, 0, 0, 0);
        step(1, 8'h22, 0, 1, 0, 0, 0);
        step(1, 8'h33, 0, 0, 0, 0, 0);
        chk("R5 sticky parity", {7'h0, status[2]}, 8'h01);
        chk("R6 sticky framing", {7'h0, status[1]}, 8'h01);
        chk("R7 overwrite", rx_data, 8'h33);

        // R8: read alone clears errors, keeps data and tx flag
        step(0, 8'h00, 0, 0, 1, 0, 0);
        step(0, 8'hFF, 1, 1, 0, 0, 1);
        chk("R8 flags cleared", {5'h0, status[2:0]}, 8'h00);
        chk("R8 tx kept", {7'h0, status[7]}, 8'h01);
        chk("R8 data kept", rx_data, 8'h33);
        // Buffer is empty now: next frame must not overrun
        step(1, 8'h44, 0, 0, 0, 0, 0);
        chk("R8 emptied", {7'h0, status[0]}, 8'h00);

        // R9: read and frame in the same cycle
        step(1, 8'h55, 0, 0, 0, 0, 0);
        chk("R7 overrun set", {7'h0, status[0]}, 8'h01);
        step(1, 8'h66, 0, 1, 0, 0, 1);
        chk("R9 collision flags", {5'h0, status[2:0]}, 8'h02);
        chk("R9 collision data", rx_data, 8'h66);

        // R3: both transmit strobes together -> set
        step(0, 8'h00, 0, 0, 0, 1, 0);
        step(0, 8'h00, 0, 0, 1, 1, 0);
        chk("R3 both strobes", {7'h0, status[7]}, 8'h01);
        step(0, 8'h00, 0, 0, 0, 1, 0);
        chk("R3 end clears", {7'h0, status[7]}, 8'h00);

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            logic fd, pb, sb, ld, te, rd;
            logic [7:0] b;
            fd = ($urandom % 100) < 35;
            b  = 8'($urandom);
            pb = ($urandom % 100) < 20;
            sb = ($urandom % 100) < 20;
            ld = ($urandom % 100) < 12;
            te = ($urandom % 100) < 12;
            rd = ($urandom % 100) < 30;
            step(fd, b, pb, sb, ld, te, rd);
        end
        finish_run();
    end
endmodule